// File: doc/BRIEF.md
# Expiring Usage Day-Countdown Timer

This block keeps track of how much usage time a security token has left. It holds two counters. The first is an elapsed-time counter for the current day, which advances on a periodic oscillator tick. The second is a count of whole days remaining, which steps down each time the day counter wraps. An owner loads the day budget with a write strobe and seals it with a lock strobe. The owner then arms the timer. Counting begins only when the next access strobe arrives after arming. While the budget is not locked, a stop strobe halts the count.

When the days counter steps down past zero, the token expires. From that point the days value reads as all ones and a write-inhibit flag blocks every write. A configuration input selects unlimited operation, in which the day budget is never consumed.

Both counters can also be read out bit by bit, least significant bit first, over a valid/ready stream. The value is captured when the readout starts, so a tick during a transfer does not change the bits already queued. A stalled consumer holds the current bit. Command strobes, the tick and the flags are plain single-cycle or level pins with no handshake.

Top module: `usage_countdown`

## Requirements
- R1: After power-on reset, day_count and days_left are 0, expired and wr_inhibit are 0, rd_valid is 0, and the timer is neither armed, running nor locked.
- R2: While running, day_count advances by one on each cycle with tick high. When the timer is not running, tick has no effect.
- R3: An access strobe starts the timer only if an arm strobe came earlier. The access strobe clears the arm state. Arming alone, or an access without arming, does not start the count.
- R4: A tick while day_count is all ones (2^DAY_W − 1) wraps day_count to 0 and lowers days_left by one in the same cycle.
- R5: A wrap while the days count is 0 sets expired and wr_inhibit. Both stay set until reset, and day_count stops advancing.
- R6: While expired, days_left reads as all ones (511 for 9 bits), and a days write has no effect.
- R7: Before lock, a days write loads days_in and may be repeated any number of times. The lock strobe is permanent until reset, and after it every days write is ignored.
- R8: Before lock, a stop strobe halts counting and clears the arm state. After lock, stop has no effect.
- R9: With unlimited high, days_left never decrements and expired never sets, while day_count still runs.
- R10: A rd_start strobe while idle captures day_count (rd_src=0, DAY_W bits) or days_left (rd_src=1, DAYS_W bits). It then streams the captured value LSB first on rd_data, with rd_last high on the final bit. A rd_start while a transfer is in progress is ignored.
- R11: While rd_valid is high and rd_ready is low, rd_data and rd_last are held and the transfer does not advance. A bit is consumed only on a cycle with rd_valid and rd_ready both high.
- R12: A days write in the same cycle as a wrap loads the written value, and no decrement is applied. A stop in the same cycle as an access leaves the timer stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | Oscillator tick enable |
| unlimited | input | 1 | Configuration: never consume days, never expire |
| cmd_arm | input | 1 | Arm strobe |
| cmd_stop | input | 1 | Stop strobe |
| cmd_lock | input | 1 | Lock strobe |
| cmd_wr_days | input | 1 | Days write strobe |
| days_in | input | DAYS_W | Value loaded by a days write |
| access | input | 1 | Access strobe |
| day_count | output | DAY_W | Elapsed ticks in the current day |
| days_left | output | DAYS_W | Days remaining (all ones once expired) |
| expired | output | 1 | Budget exhausted |
| wr_inhibit | output | 1 | Writes blocked |
| rd_start | input | 1 | Begin serial readout |
| rd_src | input | 1 | Readout source: 0 day count, 1 days count |
| rd_valid | output | 1 | Readout bit valid |
| rd_ready | input | 1 | Consumer accepts bit |
| rd_data | output | 1 | Readout bit |
| rd_last | output | 1 | Final bit of readout |

## Verification
The counting path is driven with ticks in four states: idle, armed but not accessed, stopped, and running. This shows that only the arm-then-access sequence lets ticks through. Day budgets are consumed through whole-day wraps down to the exact expiring tick, which separates the last valid day from the rollover past zero. The same wrap is then repeated with a same-cycle write and in unlimited mode. Readouts run with the consumer stalled while ticks continue, and with a second start mid-transfer, so that capture, hold and start-ignore are each observed on the stream.

// File: rtl/usage_countdown_pkg.sv
package usage_countdown_pkg;
  typedef enum logic {
    RD_DAYCLK = 1'b0,
    RD_DAYS   = 1'b1
  } rd_src_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/uc_ctrl.sv
module uc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_arm,
  input  logic cmd_stop,
  input  logic cmd_lock,
  input  logic access,
  input  logic expired,
  output logic armed,
  output logic running,
  output logic locked
);
  logic stop_ok;
  assign stop_ok = cmd_stop && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      running <= 1'b0;
      locked  <= 1'b0;
    end else begin
      if (cmd_lock) locked <= 1'b1;
      if (stop_ok) begin
        running <= 1'b0;
        armed   <= 1'b0;
      end else if (expired) begin
        running <= 1'b0;
        if (cmd_arm) armed <= 1'b1;
      end else if (access && armed) begin
        running <= 1'b1;
        armed   <= 1'b0;
      end else if (cmd_arm) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uc_day_clock.sv
module uc_day_clock #(
  parameter int DAY_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [DAY_W-1:0] count,
  output logic             wrap
);
  localparam logic [DAY_W-1:0] TOP = {DAY_W{1'b1}};

  assign wrap = adv && (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (adv) count <= count + 1'b1;
  end
endmodule

// File: rtl/uc_days_counter.sv
module uc_days_counter #(
  parameter int DAYS_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic              unlimited,
  input  logic              locked,
  input  logic              wr,
  input  logic [DAYS_W-1:0] wr_val,
  output logic [DAYS_W-1:0] days_view,
  output logic              expired
);
  logic [DAYS_W-1:0] days_q;
  logic              wr_ok;
  logic              dec;

  assign wr_ok = wr && !locked && !expired;
  assign dec   = wrap && !unlimited && !expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      days_q  <= '0;
      expired <= 1'b0;
    end else if (wr_ok) begin
      days_q <= wr_val;
    end else if (dec) begin
      days_q <= days_q - 1'b1;
      if (days_q == '0) expired <= 1'b1;
    end
  end

  assign days_view = expired ? {DAYS_W{1'b1}} : days_q;
endmodule

// File: rtl/uc_serial_out.sv
module uc_serial_out #(
  parameter int DAY_W  = 20,
  parameter int DAYS_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              src,
  input  logic [DAY_W-1:0]  day_val,
  input  logic [DAYS_W-1:0] days_val,
  input  logic              ready,
  output logic              valid,
  output logic              data,
  output logic              last
);
  import usage_countdown_pkg::*;
  localparam int W  = max_int(DAY_W, DAYS_W);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LEN_DAY  = CW'(DAY_W);
  localparam logic [CW-1:0] LEN_DAYS = CW'(DAYS_W);

  logic [W-1:0]  shreg;
  logic [CW-1:0] left;
  logic          busy;
  logic          take;

  assign take  = busy && ready;
  assign valid = busy;
  assign data  = shreg[0];
  assign last  = busy && (left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
      busy  <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        if (src == RD_DAYS) begin
          shreg <= W'(days_val);
          left  <= LEN_DAYS;
        end else begin
          shreg <= W'(day_val);
          left  <= LEN_DAY;
        end
      end
    end else if (take) begin
      shreg <= shreg >> 1;
      left  <= left - 1'b1;
      if (left == CW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/usage_countdown.sv
module usage_countdown #(
  parameter int DAY_W  = 20,
  parameter int DAYS_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              unlimited,
  input  logic              cmd_arm,
  input  logic              cmd_stop,
  input  logic              cmd_lock,
  input  logic              cmd_wr_days,
  input  logic [DAYS_W-1:0] days_in,
  input  logic              access,
  output logic [DAY_W-1:0]  day_count,
  output logic [DAYS_W-1:0] days_left,
  output logic              expired,
  output logic              wr_inhibit,
  input  logic              rd_start,
  input  logic              rd_src,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              rd_data,
  output logic              rd_last
);
  logic armed_q, run_q, lock_q, exp_q, adv, wrap;

  uc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_arm(cmd_arm), .cmd_stop(cmd_stop),
    .cmd_lock(cmd_lock), .access(access), .expired(exp_q),
    .armed(armed_q), .running(run_q), .locked(lock_q)
  );

  assign adv = tick && run_q && !exp_q;

  uc_day_clock #(.DAY_W(DAY_W)) u_day (
    .clk(clk), .rst_n(rst_n), .adv(adv), .count(day_count), .wrap(wrap)
  );

  uc_days_counter #(.DAYS_W(DAYS_W)) u_days (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .unlimited(unlimited),
    .locked(lock_q), .wr(cmd_wr_days), .wr_val(days_in),
    .days_view(days_left), .expired(exp_q)
  );

  uc_serial_out #(.DAY_W(DAY_W), .DAYS_W(DAYS_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .src(rd_src),
    .day_val(day_count), .days_val(days_left), .ready(rd_ready),
    .valid(rd_valid), .data(rd_data), .last(rd_last)
  );

  assign expired    = exp_q;
  assign wr_inhibit = exp_q;
endmodule

// File: rtl/usage_countdown_chk.sv
module usage_countdown_chk #(
  parameter int DAY_W  = 20,
  parameter int DAYS_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              unlimited,
  input logic              cmd_wr_days,
  input logic              locked,
  input logic              running,
  input logic [DAY_W-1:0]  day_count,
  input logic [DAYS_W-1:0] days_left,
  input logic              expired,
  input logic              wr_inhibit,
  input logic              rd_start,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rd_data,
  input logic              rd_last
);
  p_expired_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired && wr_inhibit);

  p_frozen_after_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> $stable(day_count));

  p_days_all_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> days_left == {DAYS_W{1'b1}});

  p_locked_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cmd_wr_days && !tick) |=> $stable(days_left));

  p_lock_permanent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_idle_tick_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(day_count));

  p_unlimited_no_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (unlimited && !expired) |=> !expired);

  p_rd_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !rd_valid) |=> rd_valid);

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_data) && $stable(rd_last));
endmodule

bind usage_countdown usage_countdown_chk #(.DAY_W(DAY_W), .DAYS_W(DAYS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .unlimited(unlimited),
  .cmd_wr_days(cmd_wr_days), .locked(lock_q), .running(run_q),
  .day_count(day_count), .days_left(days_left), .expired(expired),
  .wr_inhibit(wr_inhibit), .rd_start(rd_start), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last)
);

// File: tb/tb_usage_countdown.sv
module tb_usage_countdown;
  localparam int DAY_W  = 3;
  localparam int DAYS_W = 9;
  localparam int DAYLEN = 1 << DAY_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, unlimited = 0, cmd_arm = 0, cmd_stop = 0, cmd_lock = 0;
  logic cmd_wr_days = 0, access = 0, rd_start = 0, rd_src = 0, rd_ready = 0;
  logic [DAYS_W-1:0] days_in = '0;
  logic [DAY_W-1:0]  day_count;
  logic [DAYS_W-1:0] days_left;
  logic expired, wr_inhibit, rd_valid, rd_data, rd_last;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usage_countdown #(.DAY_W(DAY_W), .DAYS_W(DAYS_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .unlimited(unlimited),
    .cmd_arm(cmd_arm), .cmd_stop(cmd_stop), .cmd_lock(cmd_lock),
    .cmd_wr_days(cmd_wr_days), .days_in(days_in), .access(access),
    .day_count(day_count), .days_left(days_left), .expired(expired),
    .wr_inhibit(wr_inhibit), .rd_start(rd_start), .rd_src(rd_src),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1;
    repeat (n) cyc();
    tick = 0;
  endtask

  task automatic do_arm();    cmd_arm = 1;  cyc(); cmd_arm = 0;  endtask
  task automatic do_stop();   cmd_stop = 1; cyc(); cmd_stop = 0; endtask
  task automatic do_lock();   cmd_lock = 1; cyc(); cmd_lock = 0; endtask
  task automatic do_access(); access = 1;   cyc(); access = 0;   endtask
  task automatic do_write(input int v);
    days_in = DAYS_W'(v); cmd_wr_days = 1; cyc(); cmd_wr_days = 0;
  endtask

  task automatic apply_reset();
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
  endtask

  task automatic collect(input int n, input int expv, input string req, input bit poke);
    int acc = 0;
    rd_ready = 1;
    for (int i = 0; i < n; i++) begin
      chk({req, " valid"}, int'(rd_valid), 1);
      acc = acc | (int'(rd_data) << i);
      chk({req, " last"}, int'(rd_last), (i == n - 1) ? 1 : 0);
      rd_start = poke && (i == 1);
      cyc();
    end
    rd_ready = 0;
    rd_start = 0;
    chk({req, " value"}, acc, expv);
    chk({req, " idle after"}, int'(rd_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1 day_count", int'(day_count), 0);
    chk("R1 days_left", int'(days_left), 0);
    chk("R1 expired", int'(expired), 0);
    chk("R1 wr_inhibit", int'(wr_inhibit), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_idle_ticks();
    ticks(5);
    chk("R2 idle tick ignored", int'(day_count), 0);
    do_access();
    ticks(3);
    chk("R3 access without arm", int'(day_count), 0);
  endtask

  task automatic t_days_write();
    do_write(5);
    chk("R7 first write", int'(days_left), 5);
    do_write(2);
    chk("R7 rewrite", int'(days_left), 2);
  endtask

  task automatic t_start();
    do_arm();
    ticks(2);
    chk("R3 armed only", int'(day_count), 0);
    do_access();
    ticks(3);
    chk("R2 running count", int'(day_count), 3);
  endtask

  task automatic t_wrap();
    ticks(DAYLEN - 3);
    chk("R4 wrap day", int'(day_count), 0);
    chk("R4 wrap days", int'(days_left), 1);
  endtask

  task automatic t_stop();
    do_stop();
    ticks(4);
    chk("R8 stopped", int'(day_count), 0);
    do_access();
    ticks(2);
    chk("R8 stop clears arm", int'(day_count), 0);
    do_arm();
    do_access();
    ticks(2);
    chk("R8 resume", int'(day_count), 2);
  endtask

  task automatic t_priority();
    ticks(DAYLEN - 3);
    chk("R12 pre-wrap", int'(day_count), DAYLEN - 1);
    tick = 1; days_in = 9'd6; cmd_wr_days = 1;
    cyc();
    tick = 0; cmd_wr_days = 0;
    chk("R12 write beats decrement", int'(days_left), 6);
    chk("R12 wrap day", int'(day_count), 0);
    do_arm();
    cmd_stop = 1; access = 1;
    cyc();
    cmd_stop = 0; access = 0;
    ticks(2);
    chk("R12 stop beats access", int'(day_count), 0);
    do_arm();
    do_access();
    ticks(1);
    chk("R12 restart", int'(day_count), 1);
  endtask

  task automatic t_readout();
    rd_src = 0; rd_start = 1;
    cyc();
    rd_start = 0;
    chk("R10 day readout valid", int'(rd_valid), 1);
    tick = 1;
    for (int i = 0; i < 2; i++) begin
      cyc();
      chk("R11 held valid", int'(rd_valid), 1);
      chk("R11 held data", int'(rd_data), 1);
      chk("R11 held last", int'(rd_last), 0);
    end
    tick = 0;
    chk("R11 count moved meanwhile", int'(day_count), 3);
    collect(DAY_W, 1, "R10 day readout", 1'b0);
    rd_src = 1; rd_start = 1;
    cyc();
    rd_start = 0;
    rd_src = 0;
    collect(DAYS_W, 6, "R10 days readout with restart", 1'b1);
  endtask

  task automatic t_lock();
    int d0;
    do_lock();
    do_write(9);
    chk("R7 write after lock", int'(days_left), 6);
    do_stop();
    d0 = int'(day_count);
    ticks(2);
    chk("R8 stop after lock ignored", int'(day_count), (d0 + 2) % DAYLEN);
  endtask

  task automatic t_expire();
    int d0, need;
    d0 = int'(day_count);
    need = (DAYLEN - d0) + 6 * DAYLEN;
    ticks(need - 1);
    chk("R5 last day days", int'(days_left), 0);
    chk("R5 last day not expired", int'(expired), 0);
    chk("R5 last day count", int'(day_count), DAYLEN - 1);
    ticks(1);
    chk("R5 expired", int'(expired), 1);
    chk("R5 inhibit", int'(wr_inhibit), 1);
    chk("R6 all ones", int'(days_left), 511);
    ticks(3);
    chk("R5 frozen", int'(day_count), 0);
    do_write(3);
    chk("R6 write blocked", int'(days_left), 511);
  endtask

  task automatic t_unlimited();
    apply_reset();
    chk("R1 re-reset expired", int'(expired), 0);
    chk("R1 re-reset days", int'(days_left), 0);
    unlimited = 1;
    do_write(1);
    do_arm();
    do_access();
    ticks(3 * DAYLEN + 2);
    chk("R9 days kept", int'(days_left), 1);
    chk("R9 not expired", int'(expired), 0);
    chk("R9 clock runs", int'(day_count), 2);
    unlimited = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    apply_reset();
    t_reset();
    t_idle_ticks();
    t_days_write();
    t_start();
    t_wrap();
    t_stop();
    t_priority();
    t_readout();
    t_lock();
    t_expire();
    t_unlimited();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule